// File: doc/BRIEF.md
# Bit-Sliced Dot Product Engine

The engine computes the unsigned dot product of two vectors of 8-bit elements: a weight vector and an activation vector. A job starts with a one-cycle start pulse. The pulse carries the vector length and one slice-width code for each operand. The engine then takes the element pairs, one per accepted cycle, on a valid/ready stream and stores them in internal buffers.

Once loading is complete, the engine steps through every pairing of a weight bit-slice with an activation bit-slice. The activation slice index runs in the inner loop and the weight slice index in the outer loop. For each pairing the engine runs a single multiply-add per element into a narrow partial accumulator. It then shifts that partial sum into position and adds it into a 64-bit result. Narrow slices mean small multipliers, at the price of more passes over the buffer.

When the last pairing has been added, the engine raises a one-cycle done pulse. The full-precision result and the number of busy cycles the job took are available at that point and stay until the next accepted start.

Top module: `bsdp_engine`

## Requirements
- R1: When done_o pulses, result_o equals the full-precision unsigned dot product of the accepted weight and activation elements, for every combination of slice widths.
- R2: A slice-width code c (2 bits) selects slices of 2^c bits (1, 2, 4 or 8). Slice k of an element is (element >> k*2^c) masked to 2^c bits. Each operand has 8 >> c slices. The code never changes the final result.
- R3: in_ready_o is high exactly while the engine is loading. Element i of the job is the i-th pair accepted (in_valid_i and in_ready_o both high at a clock edge). Cycles with in_valid_i low accept nothing and only lengthen the load.
- R4: done_o is a single-cycle pulse. It rises 1 + L + P*(N+1) cycles after the clock edge that accepted start, where L is the number of load cycles (accepted pairs plus stall cycles), P = (8 >> wgt_code) * (8 >> act_code), and N is the effective length.
- R5: cycles_o becomes 0 after an accepted start and then increments on every busy cycle except the done cycle. It therefore reads L + P*(N+1) while done_o is high, and it holds that value until the next accepted start.
- R6: A start pulse that arrives while a job is in progress, including the done cycle, is ignored. The running job's result and timing are unchanged, and no new load begins.
- R7: A start with length 0 raises done_o on the following cycle, with result_o = 0 and cycles_o = 0, and accepts no elements.
- R8: A length above MAX_LEN (16 by default) is treated as MAX_LEN. Exactly MAX_LEN pairs are accepted and the result covers only those pairs.
- R9: Between jobs, result_o and cycles_o keep their last values until an accepted start clears them.
- R10: After reset, done_o and in_ready_o are low and result_o and cycles_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job start pulse, taken only when idle |
| len_i | input | 5 | Vector length for the job |
| wgt_code_i | input | 2 | Weight slice-width code (width = 2^code) |
| act_code_i | input | 2 | Activation slice-width code (width = 2^code) |
| in_valid_i | input | 1 | Element pair valid |
| in_ready_o | output | 1 | Engine accepts an element pair |
| in_wgt_i | input | 8 | Weight element |
| in_act_i | input | 8 | Activation element |
| done_o | output | 1 | One-cycle job-complete pulse |
| result_o | output | 64 | Accumulated dot product |
| cycles_o | output | 32 | Busy-cycle count of the last job |

## Verification
Faults inside the engine only become visible at the ports when done_o rises. A wrong slice index, a misplaced shift or a partial sum that was not cleared corrupts result_o for that job. Because every job starts from cleared state, the error does not carry into the next job. A loop counter that wraps at the wrong point changes the number of passes, so done_o rises early or late and cycles_o is off by multiples of N+1 in that same job. Mixing random lengths, slice codes and stalls with corner jobs (zero length, over-length, all-ones data, starts during busy and done cycles) exposes each of these faults within a single job.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  localparam int ELEM_W    = 8;
  localparam int CODE_W    = 2;
  localparam int SIDX_W    = $clog2(ELEM_W);
  localparam int SHIFT_W   = 8;
  localparam int PROD_W    = 2 * ELEM_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_ADD,
    ST_DONE
  } bsdp_state_e;

  // Slice k of an element for slice width 2^code.
  function automatic logic [ELEM_W-1:0] slice_of(input logic [ELEM_W-1:0] v,
                                                 input logic [SIDX_W-1:0] k,
                                                 input logic [CODE_W-1:0] code);
    logic [ELEM_W:0]   mask;
    logic [SIDX_W:0]   sh;
    logic [ELEM_W-1:0] shifted;
    sh      = (SIDX_W+1)'(k) << code;
    mask    = ((ELEM_W+1)'(1) << ((ELEM_W+1)'(1) << code)) - (ELEM_W+1)'(1);
    shifted = v >> sh;
    return shifted & mask[ELEM_W-1:0];
  endfunction
endpackage

// File: rtl/bsdp_buf.sv
module bsdp_buf
  import bsdp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ELEM_W-1:0] wr_wgt_i,
  input  logic [ELEM_W-1:0] wr_act_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] rd_wgt_o,
  output logic [ELEM_W-1:0] rd_act_o
);
  logic [ELEM_W-1:0] wgt_q [DEPTH];
  logic [ELEM_W-1:0] act_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wgt_q[g] <= '0;
        act_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        wgt_q[g] <= wr_wgt_i;
        act_q[g] <= wr_act_i;
      end
    end
  end

  assign rd_wgt_o = wgt_q[rd_idx_i];
  assign rd_act_o = act_q[rd_idx_i];
endmodule

// File: rtl/bsdp_seq.sv
module bsdp_seq
  import bsdp_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CYC_W   = 32,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CODE_W-1:0] wgt_code_i,
  input  logic [CODE_W-1:0] act_code_i,
  input  logic              in_valid_i,
  output bsdp_state_e       state_o,
  output logic              start_acc_o,
  output logic [IDX_W-1:0]  e_idx_o,
  output logic [SIDX_W-1:0] x_idx_o,
  output logic [SIDX_W-1:0] y_idx_o,
  output logic [CODE_W-1:0] wgt_code_o,
  output logic [CODE_W-1:0] act_code_o,
  output logic [CYC_W-1:0]  cycles_o
);
  bsdp_state_e       state_q;
  logic [LEN_W-1:0]  len_q, len_c, len_m1;
  logic [IDX_W-1:0]  e_q;
  logic [SIDX_W-1:0] x_q, y_q;
  logic [CODE_W-1:0] wc_q, ac_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [SIDX_W:0]   x_last, y_last;
  logic              e_end, x_end, y_end;

  assign len_c  = (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
  assign len_m1 = len_q - LEN_W'(1);
  assign e_end  = (LEN_W'(e_q) == len_m1);
  assign x_last = (SIDX_W+1)'(ELEM_W >> wc_q) - (SIDX_W+1)'(1);
  assign y_last = (SIDX_W+1)'(ELEM_W >> ac_q) - (SIDX_W+1)'(1);
  assign x_end  = ({1'b0, x_q} == x_last);
  assign y_end  = ({1'b0, y_q} == y_last);

  assign start_acc_o = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      e_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      wc_q    <= '0;
      ac_q    <= '0;
      cyc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cyc_q   <= '0;
          len_q   <= len_c;
          wc_q    <= wgt_code_i;
          ac_q    <= act_code_i;
          e_q     <= '0;
          x_q     <= '0;
          y_q     <= '0;
          state_q <= (len_c == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: begin
          cyc_q <= cyc_q + CYC_W'(1);
          if (in_valid_i) begin
            if (e_end) begin
              e_q     <= '0;
              state_q <= ST_CALC;
            end else begin
              e_q <= e_q + IDX_W'(1);
            end
          end
        end
        ST_CALC: begin
          cyc_q <= cyc_q + CYC_W'(1);
          if (e_end) begin
            e_q     <= '0;
            state_q <= ST_ADD;
          end else begin
            e_q <= e_q + IDX_W'(1);
          end
        end
        ST_ADD: begin
          cyc_q <= cyc_q + CYC_W'(1);
          state_q <= ST_CALC;
          if (y_end) begin
            y_q <= '0;
            if (x_end) state_q <= ST_DONE;
            else       x_q     <= x_q + SIDX_W'(1);
          end else begin
            y_q <= y_q + SIDX_W'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign e_idx_o    = e_q;
  assign x_idx_o    = x_q;
  assign y_idx_o    = y_q;
  assign wgt_code_o = wc_q;
  assign act_code_o = ac_q;
  assign cycles_o   = cyc_q;
endmodule

// File: rtl/bsdp_mac.sv
module bsdp_mac
  import bsdp_pkg::*;
#(
  parameter int PART_W = 21,
  parameter int RES_W  = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               calc_i,
  input  logic               add_i,
  input  logic [PROD_W-1:0]  prod_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [RES_W-1:0]   total_o
);
  logic [PART_W-1:0] part_q;
  logic [RES_W-1:0]  total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q  <= '0;
      total_q <= '0;
    end else if (clr_i) begin
      part_q  <= '0;
      total_q <= '0;
    end else if (calc_i) begin
      part_q <= part_q + PART_W'(prod_i);
    end else if (add_i) begin
      // partial is consumed and cleared for the next slice pair
      total_q <= total_q + (RES_W'(part_q) << shift_i);
      part_q  <= '0;
    end
  end

  assign total_o = total_q;
endmodule

// File: rtl/bsdp_engine.sv
module bsdp_engine
  import bsdp_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CYC_W   = 32,
  parameter int RES_W   = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int PART_W = PROD_W + LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CODE_W-1:0] wgt_code_i,
  input  logic [CODE_W-1:0] act_code_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ELEM_W-1:0] in_wgt_i,
  input  logic [ELEM_W-1:0] in_act_i,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic [CYC_W-1:0]  cycles_o
);
  bsdp_state_e        state;
  logic               start_acc, busy;
  logic [IDX_W-1:0]   e_idx;
  logic [SIDX_W-1:0]  x_idx, y_idx;
  logic [CODE_W-1:0]  wc, ac;
  logic [ELEM_W-1:0]  rd_wgt, rd_act, w_sl, a_sl;
  logic [PROD_W-1:0]  prod;
  logic [SHIFT_W-1:0] shift;

  bsdp_seq #(.MAX_LEN(MAX_LEN), .CYC_W(CYC_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (len_i),
    .wgt_code_i  (wgt_code_i),
    .act_code_i  (act_code_i),
    .in_valid_i  (in_valid_i),
    .state_o     (state),
    .start_acc_o (start_acc),
    .e_idx_o     (e_idx),
    .x_idx_o     (x_idx),
    .y_idx_o     (y_idx),
    .wgt_code_o  (wc),
    .act_code_o  (ac),
    .cycles_o    (cycles_o)
  );

  assign in_ready_o = (state == ST_LOAD);
  assign done_o     = (state == ST_DONE);
  assign busy       = (state != ST_IDLE);

  bsdp_buf #(.DEPTH(MAX_LEN)) i_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (in_valid_i && in_ready_o),
    .wr_idx_i (e_idx),
    .wr_wgt_i (in_wgt_i),
    .wr_act_i (in_act_i),
    .rd_idx_i (e_idx),
    .rd_wgt_o (rd_wgt),
    .rd_act_o (rd_act)
  );

  assign w_sl  = slice_of(rd_wgt, x_idx, wc);
  assign a_sl  = slice_of(rd_act, y_idx, ac);
  assign prod  = PROD_W'(w_sl) * PROD_W'(a_sl);
  assign shift = (SHIFT_W'(x_idx) << wc) + (SHIFT_W'(y_idx) << ac);

  bsdp_mac #(.PART_W(PART_W), .RES_W(RES_W)) i_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_acc),
    .calc_i  (state == ST_CALC),
    .add_i   (state == ST_ADD),
    .prod_i  (prod),
    .shift_i (shift),
    .total_o (result_o)
  );
endmodule

// File: rtl/bsdp_engine_chk.sv
module bsdp_engine_chk #(
  parameter int LEN_W = 5,
  parameter int CYC_W = 32,
  parameter int RES_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             in_ready_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic             busy
);
  AST_READY_WHEN_LOADING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (busy && !done_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_CYC_HOLD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(cycles_o)); // R5
  AST_CYC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (cycles_o == '0)); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy && !done_o) |=> (cycles_o == $past(cycles_o) + CYC_W'(1))); // R6
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && len_i == '0) |=> (done_o && result_o == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> ($stable(result_o) && $stable(cycles_o))); // R9
endmodule

bind bsdp_engine bsdp_engine_chk #(.LEN_W(LEN_W), .CYC_W(CYC_W), .RES_W(RES_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_i      (len_i),
  .in_ready_o (in_ready_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .cycles_o   (cycles_o),
  .busy       (busy)
);

// File: tb/test_bsdp_engine.sv
`timescale 1ns/1ps
module test_bsdp_engine;
  localparam int MAXL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  len = '0;
  logic [1:0]  wcode = '0, acode = '0;
  logic        valid = 1'b0;
  logic        ready;
  logic [7:0]  wdat = '0, adat = '0;
  logic        done;
  logic [63:0] result;
  logic [31:0] cycles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] wv [MAXL];
  logic [7:0] av [MAXL];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bsdp_engine i_bsdp_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .wgt_code_i(wcode), .act_code_i(acode), .in_valid_i(valid),
    .in_ready_o(ready), .in_wgt_i(wdat), .in_act_i(adat),
    .done_o(done), .result_o(result), .cycles_o(cycles)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned ref_dot(input int n);
    longint unsigned s = 0;
    for (int i = 0; i < n; i++) s += 64'(wv[i]) * 64'(av[i]);
    return s;
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < MAXL; i++) begin
      wv[i] = (mode == 1) ? 8'hFF : 8'($urandom);
      av[i] = (mode == 1) ? 8'hFF : 8'($urandom);
    end
  endtask

  task automatic run_job(input int n_req, input logic [1:0] wc, input logic [1:0] ac,
                         input bit stalls, input bit poke);
    int n, p, ld, t0, idx, k;
    longint unsigned exp_dot;
    bit rdy_ok;
    n = (n_req > MAXL) ? MAXL : n_req;
    p = (8 >> wc) * (8 >> ac);
    exp_dot = ref_dot(n);
    ld = 0; idx = 0; k = 0; rdy_ok = 1;
    @(negedge clk);
    start = 1'b1; len = 5'(n_req); wcode = wc; acode = ac; t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R7 done", 64'(done), 1);
      chk(result == 0, "R7 result", result, 0);
      chk(cycles == 0, "R7 cycles", 64'(cycles), 0);
      chk(ready == 1'b0, "R7 ready", 64'(ready), 0);
      @(negedge clk);
      chk(done == 1'b0, "R4 pulse", 64'(done), 0);
      return;
    end
    while (idx < n) begin
      if (!ready) rdy_ok = 0;
      if (stalls && $urandom_range(3) == 0) begin
        valid = 1'b0;
      end else begin
        valid = 1'b1; wdat = wv[idx]; adat = av[idx];
      end
      @(negedge clk);
      if (valid) idx++;
      ld++;
      if (ld > 4000) break;
    end
    valid = 1'b0;
    chk(rdy_ok, "R3 ready while loading", 64'(rdy_ok), 1);
    chk(ready == 1'b0, "R3/R8 ready after load", 64'(ready), 0);
    while (!done && k < 5000) begin
      start = poke && (k == 1);
      len = 5'd3;
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    chk(done == 1'b1, "R4 done seen", 64'(done), 1);
    chk((cyc - t0) == 1 + ld + p * (n + 1), "R4 latency", 64'(cyc - t0),
        64'(1 + ld + p * (n + 1)));
    chk(result == exp_dot, "R1 result", result, exp_dot);
    chk(cycles == 32'(ld + p * (n + 1)), "R5 cycles", 64'(cycles), 64'(ld + p * (n + 1)));
    if (poke) begin
      // start during the done cycle (R6)
      start = 1'b1; len = 5'd4;
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R6 no load after ignored start", 64'(ready), 0);
      chk(result == exp_dot, "R6 result kept", result, exp_dot);
    end else begin
      @(negedge clk);
    end
    chk(done == 1'b0, "R4 single pulse", 64'(done), 0);
    repeat (2) @(negedge clk);
    chk(result == exp_dot, "R9 result held", result, exp_dot);
    chk(cycles == 32'(ld + p * (n + 1)), "R9 cycles held", 64'(cycles), 64'(ld + p * (n + 1)));
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R10 done", 64'(done), 0);
    chk(ready == 1'b0, "R10 ready", 64'(ready), 0);
    chk(result == 0, "R10 result", result, 0);
    chk(cycles == 0, "R10 cycles", 64'(cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(0); run_job(0, 2'd1, 2'd2, 0, 0);          // R7
    fill(1); run_job(16, 2'd0, 2'd0, 0, 0);         // R1 max value, 1-bit slices
    fill(1); run_job(16, 2'd3, 2'd3, 0, 0);         // R2 full width
    fill(0); run_job(1, 2'd3, 2'd0, 0, 0);          // R2 mixed widths
    fill(0); run_job(20, 2'd2, 2'd1, 1, 0);         // R8 clamp
    fill(0); run_job(7, 2'd1, 2'd1, 1, 1);          // R6 busy and done starts
    // R2: same vectors give same result for every code pair
    fill(0);
    for (int c = 0; c < 16; c++) run_job(5, 2'(c >> 2), 2'(c), c[0], 0);
    for (int j = 0; j < 30; j++) begin
      fill(0);
      run_job($urandom_range(16), 2'($urandom), 2'($urandom),
              1'($urandom), 1'($urandom));
    end
    fill(0); run_job(0, 2'd0, 2'd0, 0, 0);          // R7 after activity
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule